// File: doc/BRIEF.md
# Serial Page-Write Master with Busy Polling

This block is the host end of a two-wire link that programs a serial memory one page at a time. A one-cycle `go` request carries a 24-bit target address and a byte count. The block then frames a write transaction on the line: a start condition, the device address byte with the write flag cleared, three address bytes, up to one page of payload bytes, and a stop condition. Payload bytes come from a show-ahead byte FIFO that the block pops one entry at a time.

After every stop, the memory runs an internal write cycle. During that cycle it refuses its own address. The block therefore opens each transaction by polling. It issues a start and the device address, and if the address is refused it drops the attempt without a stop and starts again. When an attempt is accepted, it goes straight on to the address bytes. A bounded retry count and a check of every later acknowledge turn a dead or misbehaving device into an error report. That report is a stop on the line, a `done` pulse and a raised `err`.

The serial clock is a divided copy of the system clock. Every bit cell lasts four quarter-periods of the divider. The line is open-drain: `sda_oe` high pulls the data line low.

Top module: `pw_page_writer`

## Requirements
- R1: During and straight after reset, `scl` is 1, and `sda_oe`, `busy`, `done`, `err` and `fifo_pop` are all 0.
- R2: `go` is taken only while `busy` is 0. Address and length are captured at that edge, and `busy` then stays 1 until the `done` pulse. A `go` while busy starts no second transaction and changes no byte of the running one.
- R3: Each accepted attempt begins with a start and then the byte `{DEV_ADDR,0}`. For a successful attempt, three address bytes follow, the most significant byte first. Every one of these bytes is sent most significant bit first.
- R4: The payload has `len_m1+1` bytes (1 to 128), each sent least significant bit first. One byte is popped per payload byte, and nothing is popped while `fifo_empty` is 1. While the FIFO is empty the link waits with `scl` held at 0.
- R5: A successful transaction ends with exactly one stop condition. Then `done` pulses for one cycle, `busy` falls to 0 and `err` is 0.
- R6: A refused device address leads to a new start without any stop in between. An acknowledged device address is followed directly by the address bytes, with no further start.
- R7: If `POLL_MAX` device-address attempts in a row are refused, the block sends one stop and pulses `done` with `err` at 1. The number of starts sent is then `POLL_MAX`.
- R8: A refused address byte or payload byte is followed at once by a stop, with no further byte. `done` then pulses with `err` at 1. Payload bytes up to and including the refused one are popped.
- R9: With `scl` high, the data line changes only to form a start (falling) or a stop (rising). All other data changes happen while `scl` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Request a page write (taken when idle) |
| page_addr | input | 24 | Target memory address |
| len_m1 | input | 7 | Payload byte count minus one |
| fifo_data | input | 8 | Head byte of the payload FIFO |
| fifo_empty | input | 1 | Payload FIFO holds no byte |
| fifo_pop | output | 1 | Consume the head byte |
| sda_in | input | 1 | Sampled level of the data line |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last transaction failed (held until next `go`) |

## Verification
A refused device address can be either an ordinary poll to retry or the final allowed attempt. Both outcomes are decided on the same acknowledge sample, in the same state transition. The bench's memory model refuses exactly `POLL_MAX-1` polls in one case and exactly `POLL_MAX` in another. The first must finish cleanly with `POLL_MAX` starts. The second must end with `POLL_MAX` starts, a single stop and `err` set. Any off-by-one in the retry count moves one of the two cases across the boundary.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {K_START, K_STOP, K_BYTE} cell_e;

    typedef enum logic [2:0] {S_IDLE, S_START, S_DEV, S_ADR, S_DAT, S_STOP} st_e;

    typedef struct packed {
        logic scl;
        logic oe;
    } line_t;

    // line levels for one quarter of a cell; d is the bit value (1 = release)
    function automatic line_t cell_line(cell_e k, logic [1:0] q, logic d);
        line_t r;
        case (k)
            K_START: r = '{scl: (q != 2'd0), oe: q[1]};
            K_STOP:  r = '{scl: (q != 2'd0), oe: ~q[1]};
            default: r = '{scl: (q == 2'd1) || (q == 2'd2), oe: ~d};
        endcase
        return r;
    endfunction

    // bit i of byte b in transmit order; position 8 is the acknowledge slot
    function automatic logic pick_bit(logic [7:0] b, logic [3:0] i, logic lsb);
        if (i == 4'd8) return 1'b1;
        return lsb ? b[i[2:0]] : b[3'd7 - i[2:0]];
    endfunction

endpackage

// File: rtl/pw_tick.sv
module pw_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/pw_bitphy.sv
module pw_bitphy
    import pw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_valid,
    input  cell_e      cmd_kind,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_lsb,
    input  logic       sda_in,
    output logic       cmd_ready,
    output logic       cmd_done,
    output logic       ack,
    output logic       scl,
    output logic       sda_oe
);
    logic       running;
    cell_e      kind_q;
    logic [7:0] byte_q;
    logic       lsb_q;
    logic [1:0] q;
    logic [3:0] bidx;
    line_t      ln;

    assign cmd_ready = ~running;
    assign scl       = ln.scl;
    assign sda_oe    = ln.oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            kind_q   <= K_STOP;
            byte_q   <= '0;
            lsb_q    <= 1'b0;
            q        <= '0;
            bidx     <= '0;
            ln       <= '{scl: 1'b1, oe: 1'b0};
            cmd_done <= 1'b0;
            ack      <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            if (!running && cmd_valid) begin
                running <= 1'b1;
                kind_q  <= cmd_kind;
                byte_q  <= cmd_byte;
                lsb_q   <= cmd_lsb;
                q       <= '0;
                bidx    <= '0;
                ln      <= cell_line(cmd_kind, 2'd0, pick_bit(cmd_byte, 4'd0, cmd_lsb));
            end else if (running && tick) begin
                if (q == 2'd3) begin
                    if (kind_q == K_BYTE && bidx != 4'd8) begin
                        bidx <= bidx + 4'd1;
                        q    <= '0;
                        ln   <= cell_line(K_BYTE, 2'd0, pick_bit(byte_q, bidx + 4'd1, lsb_q));
                    end else begin
                        running  <= 1'b0;
                        cmd_done <= 1'b1;
                    end
                end else begin
                    q  <= q + 2'd1;
                    ln <= cell_line(kind_q, q + 2'd1, pick_bit(byte_q, bidx, lsb_q));
                    if (kind_q == K_BYTE && bidx == 4'd8 && q == 2'd1)
                        ack <= ~sda_in;
                end
            end
        end
    end

    // R9
    start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (scl && $past(scl) && $rose(sda_oe)) |-> kind_q == K_START);
    // R9
    stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (scl && $past(scl) && $fell(sda_oe)) |-> kind_q == K_STOP);
endmodule

// File: rtl/pw_page_writer.sv
module pw_page_writer
    import pw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h50,
    parameter int         PAGE_BYTES = 128,
    parameter int         ADDR_BYTES = 3,
    parameter int         DIV        = 4,
    parameter int         POLL_MAX   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic [8*ADDR_BYTES-1:0]  page_addr,
    input  logic [$clog2(PAGE_BYTES)-1:0] len_m1,
    input  logic [7:0]               fifo_data,
    input  logic                     fifo_empty,
    output logic                     fifo_pop,
    input  logic                     sda_in,
    output logic                     scl,
    output logic                     sda_oe,
    output logic                     busy,
    output logic                     done,
    output logic                     err
);
    localparam int LEN_W = $clog2(PAGE_BYTES);
    localparam int AW    = 8 * ADDR_BYTES;
    localparam int AIW   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int TW    = $clog2(POLL_MAX + 1);

    st_e            st;
    logic           issued;
    logic [AW-1:0]  addr_q;
    logic [AW-1:0]  ashift;
    logic [LEN_W-1:0] len_q, cnt;
    logic [AIW-1:0] aidx;
    logic [TW-1:0]  tries;
    logic           err_pend;

    logic       tick, ph_ready, ph_done, ph_ack, cmd_valid, cmd_lsb;
    cell_e      cmd_kind;
    logic [7:0] cmd_byte;

    assign ashift = addr_q << (8 * aidx);
    assign busy   = (st != S_IDLE);

    always_comb begin
        case (st)
            S_START: cmd_kind = K_START;
            S_STOP:  cmd_kind = K_STOP;
            default: cmd_kind = K_BYTE;
        endcase
        case (st)
            S_DEV:   cmd_byte = {DEV_ADDR, 1'b0};
            S_ADR:   cmd_byte = ashift[AW-1 -: 8];
            default: cmd_byte = fifo_data;
        endcase
        cmd_lsb   = (st == S_DAT);
        cmd_valid = busy && !issued && ph_ready && (st != S_DAT || !fifo_empty);
        fifo_pop  = cmd_valid && (st == S_DAT);
    end

    pw_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    pw_bitphy u_phy (
        .clk(clk), .rst(rst), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(cmd_byte),
        .cmd_lsb(cmd_lsb), .sda_in(sda_in),
        .cmd_ready(ph_ready), .cmd_done(ph_done), .ack(ph_ack),
        .scl(scl), .sda_oe(sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            issued   <= 1'b0;
            addr_q   <= '0;
            len_q    <= '0;
            cnt      <= '0;
            aidx     <= '0;
            tries    <= '0;
            err_pend <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == S_IDLE) begin
                if (go) begin
                    addr_q   <= page_addr;
                    len_q    <= len_m1;
                    cnt      <= '0;
                    aidx     <= '0;
                    tries    <= '0;
                    err_pend <= 1'b0;
                    err      <= 1'b0;
                    issued   <= 1'b0;
                    st       <= S_START;
                end
            end else if (cmd_valid) begin
                issued <= 1'b1;
            end else if (ph_done) begin
                issued <= 1'b0;
                case (st)
                    S_START: st <= S_DEV;
                    S_DEV: begin
                        if (ph_ack) begin
                            st <= S_ADR;
                        end else if (tries == TW'(POLL_MAX - 1)) begin
                            err_pend <= 1'b1;
                            st       <= S_STOP;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= S_START;
                        end
                    end
                    S_ADR: begin
                        if (!ph_ack) begin
                            err_pend <= 1'b1;
                            st       <= S_STOP;
                        end else if (aidx == AIW'(ADDR_BYTES - 1)) begin
                            st <= S_DAT;
                        end else begin
                            aidx <= aidx + 1'b1;
                        end
                    end
                    S_DAT: begin
                        if (!ph_ack) begin
                            err_pend <= 1'b1;
                            st       <= S_STOP;
                        end else if (cnt == len_q) begin
                            st <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                        err  <= err_pend;
                    end
                endcase
            end
        end
    end

    // R2
    go_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (busy && st == S_START));
    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(st) == S_STOP));
    // R7
    poll_limit_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> tries < TW'(POLL_MAX));
    // R8
    nack_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_done && !ph_ack && (st == S_ADR || st == S_DAT)) |=> (st == S_STOP && err_pend));
endmodule

// File: tb/pw_page_writer_bench.sv
module pw_page_writer_bench;
    localparam int POLL_MAX = 4;
    localparam logic [7:0] DEV_BYTE = 8'hA0;

    typedef struct packed {
        logic [23:0] a;
        logic [6:0]  l;
        logic [3:0]  b;
        logic [7:0]  n;
        logic        e;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{a: 24'h012345, l: 7'd3,   b: 4'd0, n: 8'd255, e: 1'b0},
        '{a: 24'h00ABCD, l: 7'd0,   b: 4'd2, n: 8'd255, e: 1'b0},
        '{a: 24'h7F0080, l: 7'd127, b: 4'd1, n: 8'd255, e: 1'b0},
        '{a: 24'h5A5A00, l: 7'd2,   b: 4'd3, n: 8'd255, e: 1'b0},
        '{a: 24'h123456, l: 7'd2,   b: 4'd4, n: 8'd255, e: 1'b1},
        '{a: 24'hC0FFEE, l: 7'd5,   b: 4'd0, n: 8'd2,   e: 1'b1},
        '{a: 24'h000100, l: 7'd3,   b: 4'd1, n: 8'd5,   e: 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic [23:0] page_addr = '0;
    logic [6:0]  len_m1 = '0;
    logic [7:0]  fifo_data;
    logic        fifo_empty, fifo_pop, scl, sda_oe, busy, done, err;

    always #5 clk = ~clk;

    // payload FIFO model
    logic [7:0] fifo_mem [0:127];
    int rd_ptr = 0;
    int avail = 0;
    int pops = 0;
    assign fifo_data  = fifo_mem[rd_ptr[6:0]];
    assign fifo_empty = (rd_ptr >= avail);
    always @(posedge clk) if (fifo_pop) begin rd_ptr <= rd_ptr + 1; pops <= pops + 1; end

    // memory device model
    logic dev_drive = 1'b0;
    wire  sda_line = ~(sda_oe | dev_drive);
    int   bitcnt = 0, k = 0, starts = 0, stops = 0, busy_left = 0, nack_at = 255;
    logic ackph = 1'b0;
    logic [7:0] sr = '0;
    logic [7:0] rx [0:139];

    always @(negedge sda_line) if (scl) begin starts++; bitcnt = 0; k = 0; ackph = 1'b0; end
    always @(posedge sda_line) if (scl) stops++;
    always @(posedge scl) if (bitcnt < 8) begin
        sr = {sr[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 8 && k < 140) rx[k] = sr;
    end
    always @(negedge scl) begin
        if (ackph) begin
            dev_drive <= 1'b0; ackph = 1'b0; bitcnt = 0; k++;
        end else if (bitcnt == 8) begin
            if (k == 0) begin
                if (busy_left > 0) begin busy_left--; dev_drive <= 1'b0; end
                else dev_drive <= 1'b1;
            end else dev_drive <= (k != nack_at);
            ackph = 1'b1;
        end
    end

    pw_page_writer #(.POLL_MAX(POLL_MAX)) u_pw_page_writer (
        .clk(clk), .rst(rst), .go(go), .page_addr(page_addr), .len_m1(len_m1),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .sda_in(sda_line), .scl(scl), .sda_oe(sda_oe),
        .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 180000) begin
            errors++;
            $display("FAIL R5 watchdog: no completion actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
    endfunction

    task automatic launch(input int vi, input int av);
        for (int i = 0; i < 128; i++) fifo_mem[i] = 8'(i * 37 + vi * 11 + 5);
        rd_ptr = 0; pops = 0; avail = av;
        starts = 0; stops = 0; k = 0; bitcnt = 0;
        busy_left = int'(VEC[vi].b); nack_at = int'(VEC[vi].n);
        @(negedge clk);
        page_addr = VEC[vi].a; len_m1 = VEC[vi].l; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R2", "busy after go", int'(busy), 1);
        repeat (60) @(negedge clk);
        page_addr = 24'hFFFFFF; len_m1 = 7'd127; go = 1'b1;   // ignored while busy
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic finish_vec(input int vi);
        int nb, exp_starts, exp_bytes, exp_pops, bad;
        while (!done) @(negedge clk);
        chk("R5/R7/R8", "err at done", int'(err), int'(VEC[vi].e));
        nb = int'(VEC[vi].b);
        exp_starts = (nb < POLL_MAX) ? nb + 1 : POLL_MAX;
        if (nb >= POLL_MAX) exp_bytes = 1;
        else if (VEC[vi].n != 8'd255) exp_bytes = int'(VEC[vi].n) + 1;
        else exp_bytes = 4 + int'(VEC[vi].l) + 1;
        exp_pops = (exp_bytes > 4) ? exp_bytes - 4 : 0;
        chk("R6/R7/R9", "start count", starts, exp_starts);
        chk("R5/R8", "stop count", stops, 1);
        chk("R4/R8", "bytes in final frame", k, exp_bytes);
        chk("R4", "fifo pops", pops, exp_pops);
        chk("R3", "device address byte", int'(rx[0]), int'(DEV_BYTE));
        if (exp_bytes >= 4) begin
            chk("R3", "address high byte", int'(rx[1]), int'(VEC[vi].a[23:16]));
            chk("R3", "address mid byte", int'(rx[2]), int'(VEC[vi].a[15:8]));
            chk("R3", "address low byte", int'(rx[3]), int'(VEC[vi].a[7:0]));
        end
        bad = 0;
        for (int i = 4; i < exp_bytes; i++)
            if (rev8(rx[i]) != fifo_mem[i - 4]) bad++;
        chk("R4", "payload LSB-first mismatches", bad, 0);
        repeat (20) @(negedge clk);
        chk("R2", "idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "scl in reset", int'(scl), 1);
        chk("R1", "sda_oe in reset", int'(sda_oe), 0);
        chk("R1", "busy/done/err/pop in reset", int'({busy, done, err, fifo_pop}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "scl after reset", int'(scl), 1);
        chk("R1", "busy/done/err after reset", int'({busy, done, err}), 0);

        for (int vi = 0; vi < NV; vi++) begin
            launch(vi, 128);
            finish_vec(vi);
        end

        // FIFO starvation: two bytes available of four
        launch(0, 2);
        while (rd_ptr < 2) @(negedge clk);
        repeat (400) @(negedge clk);
        chk("R4", "scl low while fifo empty", int'(scl), 0);
        chk("R4", "still busy while fifo empty", int'(busy), 1);
        chk("R4", "pops stalled at two", pops, 2);
        avail = 128;
        finish_vec(0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule